// File: doc/BRIEF.md
# SDRAM Read Burst Data Sequencer

This block is the read side of a behavioural synchronous DRAM core. When a decoded read command arrives with a bank and an 8-bit starting column, it latches the burst length that is currently programmed and walks a sequence of column addresses into a synchronous storage array. The array returns each word one cycle later. A latency pipeline then marks each word valid on the data bus and enables the bus driver. The first word appears a programmed CAS latency of 2 or 3 cycles after the command, and the remaining words follow with no gaps.

The fixed burst lengths are 1, 2, 4 and 8, and they wrap inside their aligned column window. Full-page mode runs through all 256 columns, wraps from the last column to column 0, and keeps going until a terminate strobe or a new read arrives. A new read during a burst replaces the old burst, and the bus stays driven across the change. A terminate strobe stops column generation at once. The words already in flight are still driven, and then the bus goes to high impedance.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: While reset is asserted and after it is released with no read, `arr_rd`, `dq_valid` and `dq_oe` are low.
- R2: A read sampled at a rising edge makes `arr_rd` high in the following cycle, with `arr_col` equal to the sampled `rd_col`.
- R3: For burst codes 1, 2 and 3 (lengths 2, 4, 8) the column address increments by one per cycle. Only the low log2(length) bits change, so the address wraps inside the aligned window.
- R4: Burst code 7 selects full page. The column increments each cycle, wraps from 255 to 0, and `arr_rd` stays high until a terminate or a new read.
- R5: A fixed burst issues exactly its length in consecutive `arr_rd` cycles, then `arr_rd` falls. Code 0 gives one word.
- R6: `dq_valid` follows `arr_rd` delayed by CL-1 cycles, so the first word is valid CL cycles after the read command. CL is 2 when `cl3` is 0 and 3 when `cl3` is 1.
- R7: Later words of a burst are valid on consecutive cycles, with no gaps.
- R8: A terminate strobe without a read ends `arr_rd` in the next cycle. Words already issued are still marked valid, after which `dq_valid` falls. A read in the same cycle as a terminate takes priority.
- R9: A read during a burst restarts the sequence at the new column. `dq_valid` stays high across the switch.
- R10: `dq_oe` is high exactly while `dq_valid` is high, so the bus is high impedance when no word is due.
- R11: The burst length is latched at the read command, and later changes of `bl_code` do not affect a running burst. Codes 4 to 6 behave as length 1.
- R12: `arr_bank` holds the bank sampled with the read for every word of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Decoded read command strobe |
| rd_bank | input | 2 | Bank selected by the read |
| rd_col | input | 8 | Starting column of the read |
| bl_code | input | 3 | Programmed burst length: 0=1, 1=2, 2=4, 3=8, 7=full page |
| cl3 | input | 1 | Programmed CAS latency: 0 gives 2, 1 gives 3 |
| term | input | 1 | Burst-terminate strobe |
| arr_rd | output | 1 | Array read enable |
| arr_bank | output | 2 | Array bank address |
| arr_col | output | 8 | Array column address |
| dq_valid | output | 1 | Data word valid on the bus this cycle |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The array address and read enable are due one cycle after the edge that samples a read or terminate. The bus valid and enable are due CL-1 cycles after that, so a word reaches the bus CL cycles after its command. The bench drives inputs on the falling edge and advances a queue-based model at each rising edge. It keeps a short history of the expected array enable, so the bus outputs are compared against the entry CL-1 cycles back. Every comparison is made at the next falling edge. CAS latency changes only while the block is idle, so the history never mixes the two settings.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  localparam int COL_W  = 8;
  localparam int BANK_W = 2;
  localparam int CODE_W = 3;
  localparam int MIN_CL = 2;
  localparam int MAX_CL = 3;

  localparam logic [CODE_W-1:0] CODE_PAGE = 3'd7;

  // Window mask for a burst code; for fixed lengths it also equals length-1.
  function automatic logic [COL_W-1:0] win_mask(input logic [CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    case (code)
      3'd1:    m = COL_W'(1);
      3'd2:    m = COL_W'(3);
      3'd3:    m = COL_W'(7);
      3'd7:    m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Next column: the bits above the window are held, the bits inside it count up.
  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] col,
                                                 input logic [COL_W-1:0] mask);
    logic [COL_W-1:0] inc;
    inc = col + COL_W'(1);
    return (col & ~mask) | (inc & mask);
  endfunction
endpackage

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              term,
  output logic              busy,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col
);
  logic              page_q;
  logic [COL_W-1:0]  mask_q;
  logic [COL_W-1:0]  left_q;

  // named events for the checks
  logic start_ev, stop_ev, last_ev, step_ev;
  assign start_ev = rd_cmd;
  assign stop_ev  = !rd_cmd && term;
  assign last_ev  = busy && !rd_cmd && !term && !page_q && (left_q == '0);
  assign step_ev  = busy && !rd_cmd && !term && !last_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      page_q <= 1'b0;
      mask_q <= '0;
      left_q <= '0;
      col    <= '0;
      bank   <= '0;
    end else if (start_ev) begin
      busy   <= 1'b1;
      page_q <= (bl_code == CODE_PAGE);
      mask_q <= win_mask(bl_code);
      left_q <= win_mask(bl_code);
      col    <= rd_col;
      bank   <= rd_bank;
    end else if (stop_ev || last_ev) begin
      busy   <= 1'b0;
      page_q <= 1'b0;
    end else if (step_ev) begin
      col    <= next_col(col, mask_q);
      left_q <= left_q - COL_W'(1);
    end
  end

  // R2
  rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> busy && (col == $past(rd_col)));

  // R3
  col_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_cmd && !term && !last_ev) |=>
      (((col ^ $past(col)) & ~mask_q) == '0) && (col != $past(col)));

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && page_q && !rd_cmd && !term) |=> busy);

  // R8
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !rd_cmd) |=> !busy);

  // R12
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_cmd) |=> $stable(bank));
endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe
  import sdram_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cl3,
  input  logic word_in,
  output logic word_out
);
  localparam int DEPTH = MAX_CL - 1;

  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= word_in;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[g] <= 1'b0;
      else        sh[g] <= sh[g-1];
    end
  end

  assign word_out = cl3 ? sh[MAX_CL-2] : sh[MIN_CL-2];

  // R6
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cl3 |-> (word_out == $past(word_in)));

  // R6
  lat_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3 && $past(cl3)) |-> (word_out == $past(word_in, 2)));
endmodule

// File: rtl/sdram_rd_burst_seq.sv
module sdram_rd_burst_seq
  import sdram_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              cl3,
  input  logic              term,
  output logic              arr_rd,
  output logic [BANK_W-1:0] arr_bank,
  output logic [COL_W-1:0]  arr_col,
  output logic              dq_valid,
  output logic              dq_oe
);
  logic word_due;

  sdram_col_gen u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_cmd  (rd_cmd),
    .rd_bank (rd_bank),
    .rd_col  (rd_col),
    .bl_code (bl_code),
    .term    (term),
    .busy    (arr_rd),
    .bank    (arr_bank),
    .col     (arr_col)
  );

  sdram_lat_pipe u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl3      (cl3),
    .word_in  (arr_rd),
    .word_out (word_due)
  );

  assign dq_valid = word_due;
  assign dq_oe    = word_due;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(rd_cmd)) |-> !arr_rd);
endmodule

// File: tb/test_sdram_rd_burst_seq.sv
module test_sdram_rd_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_cmd = 1'b0;
  logic [1:0] rd_bank = '0;
  logic [7:0] rd_col = '0;
  logic [2:0] bl_code = '0;
  logic       cl3 = 1'b0;
  logic       term = 1'b0;
  logic       arr_rd, dq_valid, dq_oe;
  logic [1:0] arr_bank;
  logic [7:0] arr_col;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit  m_act = 0;
  int  m_col = 0;
  int  m_bank = 0;
  bit  m_page = 0;
  int  m_q[$];
  bit  m_hist[3] = '{0, 0, 0};
  bit  m_cl3 = 0;

  always #10 clk = ~clk;

  sdram_rd_burst_seq i_sdram_rd_burst_seq (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_bank(rd_bank),
    .rd_col(rd_col), .bl_code(bl_code), .cl3(cl3), .term(term),
    .arr_rd(arr_rd), .arr_bank(arr_bank), .arr_col(arr_col),
    .dq_valid(dq_valid), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int blen(input int code);
    if (code == 1) return 2;
    if (code == 2) return 4;
    if (code == 3) return 8;
    return 1;
  endfunction

  task automatic model_edge(input bit r, input int c, input int b, input int code, input bit t);
    if (r) begin
      m_act = 1; m_col = c; m_bank = b; m_page = (code == 7);
      m_q.delete();
      if (!m_page) begin
        int n = blen(code);
        int base = c - (c % n);
        for (int i = 1; i < n; i++) m_q.push_back(base + ((c + i) % n));
      end
    end else if (t) begin
      m_act = 0; m_page = 0; m_q.delete();
    end else if (m_act) begin
      if (m_page) m_col = (m_col + 1) % 256;
      else if (m_q.size() > 0) m_col = m_q.pop_front();
      else m_act = 0;
    end
    m_hist[2] = m_hist[1];
    m_hist[1] = m_hist[0];
    m_hist[0] = m_act;
  endtask

  // one clock: drive at falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic step(input string tag, input bit r = 0, input int c = 0, input int b = 0,
                      input int code = 0, input bit t = 0);
    bit exp_v;
    rd_cmd = r; rd_col = 8'(c); rd_bank = 2'(b); term = t;
    if (r) bl_code = 3'(code);
    @(posedge clk);
    model_edge(r, c, b, code, t);
    @(negedge clk);
    rd_cmd = 0; term = 0;
    check(tag, arr_rd, m_act, "arr_rd");
    if (m_act) begin
      check(tag, arr_col, m_col, "arr_col");
      check("R12", arr_bank, m_bank, "arr_bank");
    end
    exp_v = m_cl3 ? m_hist[2] : m_hist[1];
    check(tag, dq_valid, exp_v, "dq_valid");
    check("R10", dq_oe, exp_v, "dq_oe");
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", arr_rd, 0, "arr_rd in reset");
    check("R1", dq_valid, 0, "dq_valid in reset");
    check("R1", dq_oe, 0, "dq_oe in reset");
    rst_n = 1'b1;
    idle("R1", 3);

    // R2 R5 R6: single word, CL2
    step("R2", 1, 8'h35, 1, 0);
    idle("R5", 5);
    // R3 R6 R7: length 4 with wrap inside window, CL3
    cl3 = 1; m_cl3 = 1;
    step("R3", 1, 8'h0E, 2, 2);
    idle("R7", 8);
    // R3: length 2
    step("R3", 1, 8'h41, 3, 1);
    idle("R6", 6);
    // R3 R5: length 8, CL2
    cl3 = 0; m_cl3 = 0;
    step("R3", 1, 8'h7D, 0, 3);
    idle("R5", 11);
    // R4 R8: full page from 0xFD, wraps past 255, then terminated
    step("R4", 1, 8'hFD, 2, 7);
    idle("R4", 6);
    step("R8", 0, 0, 0, 0, 1);
    idle("R8", 5);
    // R9: new read in the middle of a length-8 burst
    step("R9", 1, 8'h10, 1, 3);
    idle("R9", 3);
    step("R9", 1, 8'hA6, 3, 2);
    idle("R9", 7);
    // R11: code latched at read, later change ignored; reserved code as length 1
    step("R11", 1, 8'h22, 0, 2);
    bl_code = 3'd7;
    idle("R11", 7);
    step("R11", 1, 8'h90, 2, 5);
    idle("R11", 5);
    // R8: terminate a fixed burst under CL3, and read beating a terminate
    cl3 = 1; m_cl3 = 1;
    step("R8", 1, 8'h58, 1, 3);
    idle("R8", 2);
    step("R8", 0, 0, 0, 0, 1);
    idle("R8", 5);
    step("R4", 1, 8'hFF, 0, 7);
    step("R4");
    step("R8", 1, 8'h03, 3, 1, 1);
    idle("R8", 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule